// File: doc/BRIEF.md
# Programmable Interval Timer Channel

A single 16-bit down-counting timer channel driven by a byte-wide host port. The host writes a control byte that picks one of three operating modes (one-shot terminal flag, periodic rate pulse, software strobe) and a byte-load format. It then loads the count one or two bytes at a time. The channel decrements once per cycle in which `tick` is high, and drives `out_q` at a level set by the mode.

A control write stops the channel outright. No decrement and no output event happens after it until a complete new count has been loaded. A loaded count is moved into the counter only on the first `tick` after the load completes. Until that tick, `cnt_valid` is low to mark readback as not yet meaningful. A latch command freezes a snapshot of the counter for the host to read back in the selected byte format.

Top module: `tmr_channel`

## Requirements
- R1: A control write (`wr_ctrl`=1, `wr_data[7]`=0) clears `cnt_valid` on the next cycle. It also stops the count: no decrement and no output change follows, whatever `tick` does, until a complete new count is loaded.
- R2: The control byte holds the mode in bits [1:0] (00 one-shot, 01 rate, 10 strobe) and the format in bits [3:2]. In one-shot mode, `out_q` is low on the cycle after the control write and on the cycle after any count byte is written. It stays low until the count reaches terminal.
- R3: In one-shot mode, `out_q` goes high in the cycle in which the counter steps from 1 to 0. It stays high while the counter keeps decrementing and wraps from 0 to FFFFh.
- R4: In rate mode, `out_q` is high after the control write and while a load is pending. It is low for exactly one tick while the counter holds 1. On the following tick the counter reloads the stored count and `out_q` returns high, so the cycle repeats every N ticks.
- R5: In strobe mode, `out_q` is high after the control write. It is low for exactly one tick when the counter first reaches 0. The counter does not reload and wraps to FFFFh with `out_q` high.
- R6: After the load completes, `cnt_valid` stays low until the next tick. That tick copies the loaded value into the counter and sets `cnt_valid`. Each later tick decrements the counter by one.
- R7: Format 01 loads one byte as the low byte, with the high byte zero. Format 10 loads one byte as the high byte, with the low byte zero. Format 11 (and 00) loads low then high. In that format, the first byte freezes a running count and only the second byte completes the load.
- R8: A control byte with bit 7 set is a latch command. It copies the counter into a hold register. Reads then return the held value, low byte first in two-byte format, until every byte of the format has been read. A further latch while a value is held is ignored. Reads with nothing latched return the live counter.
- R9: A control write resets the read byte order, so the next two-byte read starts with the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_ctrl | input | 1 | 1 selects the control byte, 0 the count register |
| wr_data | input | 8 | Written byte |
| rd_en | input | 1 | Read strobe; advances the byte order and releases the latch |
| rd_data | output | 8 | Byte presented for reading (combinational) |
| tick | input | 1 | Count enable, one decrement per high cycle |
| out_q | output | 1 | Timer output pin |
| cnt_valid | output | 1 | High once the loaded count is in the counter |

## Verification
Writes and ticks take effect at the edge that samples them, so `out_q` and `cnt_valid` are due one cycle after the strobe. The bench drives each strobe for one cycle from the falling edge and reads the results at the following falling edge. After a load, the first tick only transfers the count, so N ticks leave the counter at N-(N_ticks-1). The expected counts and levels in the vector table are worked out this way. `rd_data` reflects the register state directly and is sampled before `rd_en` is pulsed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MODE_ONESHOT = 2'b00,
        MODE_RATE    = 2'b01,
        MODE_STROBE  = 2'b10
    } mode_e;

    typedef enum logic [1:0] {
        FMT_LO   = 2'b01,
        FMT_HI   = 2'b10,
        FMT_LOHI = 2'b11
    } fmt_e;

    typedef struct packed {
        mode_e mode;
        fmt_e  fmt;
    } cfg_t;

    function automatic cfg_t decode_cfg(input logic [BYTE_W-1:0] b);
        cfg_t c;
        case (b[1:0])
            2'b01:   c.mode = MODE_RATE;
            2'b10:   c.mode = MODE_STROBE;
            default: c.mode = MODE_ONESHOT;
        endcase
        case (b[3:2])
            2'b01:   c.fmt = FMT_LO;
            2'b10:   c.fmt = FMT_HI;
            default: c.fmt = FMT_LOHI;
        endcase
        return c;
    endfunction

    function automatic logic idle_level(input mode_e m);
        return (m != MODE_ONESHOT);
    endfunction
endpackage

// File: rtl/tmr_load.sv
module tmr_load
    import tmr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_ctrl,
    input  logic [BW-1:0] wr_data,
    output cfg_t          cfg_q,
    output cfg_t          cfg_new,
    output logic          cfg_wr,
    output logic          latch_cmd,
    output logic          load_start,
    output logic          load_done,
    output logic [CW-1:0] reload_q
);
    localparam int HB = CW - BW;

    logic          byte_hi;
    logic [BW-1:0] lo_byte;
    logic          data_wr;

    assign cfg_new   = decode_cfg(wr_data);
    assign cfg_wr    = wr_en && wr_ctrl && !wr_data[BW-1];
    assign latch_cmd = wr_en && wr_ctrl &&  wr_data[BW-1];
    assign data_wr   = wr_en && !wr_ctrl;

    always_comb begin
        load_start = 1'b0;
        load_done  = 1'b0;
        if (data_wr) begin
            if (cfg_q.fmt == FMT_LOHI && !byte_hi) load_start = 1'b1;
            else                                   load_done  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '{mode: MODE_ONESHOT, fmt: FMT_LOHI};
            byte_hi  <= 1'b0;
            lo_byte  <= '0;
            reload_q <= '0;
        end else if (cfg_wr) begin
            cfg_q   <= cfg_new;
            byte_hi <= 1'b0;
        end else if (data_wr) begin
            case (cfg_q.fmt)
                FMT_LO: reload_q <= {{HB{1'b0}}, wr_data};
                FMT_HI: reload_q <= {wr_data, {HB{1'b0}}};
                default: begin
                    if (!byte_hi) lo_byte  <= wr_data;
                    else          reload_q <= {wr_data, lo_byte};
                    byte_hi <= !byte_hi;
                end
            endcase
        end
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  mode_e         mode,
    input  mode_e         new_mode,
    input  logic          cfg_wr,
    input  logic          load_start,
    input  logic          load_done,
    input  logic [CW-1:0] reload,
    output logic [CW-1:0] cnt_q,
    output logic          out_q,
    output logic          valid_q
);
    logic run_q, pend_q, fired_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            run_q   <= 1'b0;
            pend_q  <= 1'b0;
            valid_q <= 1'b0;
            out_q   <= 1'b0;
            fired_q <= 1'b0;
        end else if (cfg_wr) begin
            run_q   <= 1'b0;
            pend_q  <= 1'b0;
            valid_q <= 1'b0;
            fired_q <= 1'b0;
            out_q   <= idle_level(new_mode);
        end else if (load_done) begin
            run_q   <= 1'b0;
            pend_q  <= 1'b1;
            valid_q <= 1'b0;
            if (mode == MODE_ONESHOT) out_q <= 1'b0;
        end else if (load_start) begin
            run_q <= 1'b0;
            if (mode == MODE_ONESHOT) out_q <= 1'b0;
        end else if (tick) begin
            if (pend_q) begin
                cnt_q   <= reload;
                run_q   <= 1'b1;
                pend_q  <= 1'b0;
                valid_q <= 1'b1;
                fired_q <= 1'b0;
            end else if (run_q) begin
                case (mode)
                    MODE_RATE: begin
                        if (cnt_q == CW'(1)) begin
                            cnt_q <= reload;
                            out_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                            out_q <= (cnt_q != CW'(2));
                        end
                    end
                    MODE_STROBE: begin
                        cnt_q <= cnt_q - 1'b1;
                        if (!fired_q && cnt_q == CW'(1)) begin
                            out_q   <= 1'b0;
                            fired_q <= 1'b1;
                        end else begin
                            out_q <= 1'b1;
                        end
                    end
                    default: begin
                        cnt_q <= cnt_q - 1'b1;
                        if (cnt_q == CW'(1)) out_q <= 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_rdbk.sv
module tmr_rdbk
    import tmr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr,
    input  logic          latch_cmd,
    input  logic          rd_en,
    input  fmt_e          fmt,
    input  logic [CW-1:0] cnt,
    output logic [BW-1:0] rd_data
);
    logic [CW-1:0] hold_q;
    logic          held_q, rd_hi_q, pick_hi;
    logic [CW-1:0] src;

    assign src     = held_q ? hold_q : cnt;
    assign pick_hi = (fmt == FMT_HI) || (fmt == FMT_LOHI && rd_hi_q);
    assign rd_data = pick_hi ? src[CW-1 -: BW] : src[BW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            held_q  <= 1'b0;
            rd_hi_q <= 1'b0;
        end else if (cfg_wr) begin
            held_q  <= 1'b0;
            rd_hi_q <= 1'b0;
        end else begin
            if (latch_cmd && !held_q) begin
                hold_q <= cnt;
                held_q <= 1'b1;
            end
            if (rd_en) begin
                if (fmt == FMT_LOHI) rd_hi_q <= !rd_hi_q;
                if (fmt != FMT_LOHI || rd_hi_q) held_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_ctrl,
    input  logic [BW-1:0] wr_data,
    input  logic          rd_en,
    output logic [BW-1:0] rd_data,
    input  logic          tick,
    output logic          out_q,
    output logic          cnt_valid
);
    cfg_t          cfg_q, cfg_new;
    logic          cfg_wr, latch_cmd, load_start, load_done;
    logic [CW-1:0] reload, cnt;
    mode_e         cur_mode;

    assign cur_mode = cfg_q.mode;

    tmr_load #(.CW(CW), .BW(BW)) u_load (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
        .cfg_q(cfg_q), .cfg_new(cfg_new), .cfg_wr(cfg_wr), .latch_cmd(latch_cmd),
        .load_start(load_start), .load_done(load_done), .reload_q(reload)
    );

    tmr_core #(.CW(CW)) u_core (
        .clk(clk), .rst(rst), .tick(tick), .mode(cfg_q.mode), .new_mode(cfg_new.mode),
        .cfg_wr(cfg_wr), .load_start(load_start), .load_done(load_done),
        .reload(reload), .cnt_q(cnt), .out_q(out_q), .valid_q(cnt_valid)
    );

    tmr_rdbk #(.CW(CW), .BW(BW)) u_rdbk (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .latch_cmd(latch_cmd), .rd_en(rd_en),
        .fmt(cfg_q.fmt), .cnt(cnt), .rd_data(rd_data)
    );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       wr_ctrl,
    input logic [7:0] wr_data,
    input logic       tick,
    input logic       out_q,
    input logic       cnt_valid,
    input logic [1:0] mode
);
    p_ctrl_drops_valid_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ctrl && !wr_data[7]) |=> !cnt_valid);

    p_oneshot_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ctrl && !wr_data[7] && wr_data[1:0] == 2'b00) |=> !out_q);

    p_rate_idle_high_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ctrl && !wr_data[7] && wr_data[1:0] == 2'b01) |=> out_q);

    p_strobe_idle_high_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ctrl && !wr_data[7] && wr_data[1:0] == 2'b10) |=> out_q);

    p_valid_needs_tick_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(cnt_valid) |-> $past(tick));

    p_oneshot_rise_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_q) && mode == 2'b00) |-> $past(tick));

    p_out_fall_cause_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(out_q) |-> $past(tick || wr_en));
endmodule

bind tmr_channel tmr_channel_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .tick(tick), .out_q(out_q), .cnt_valid(cnt_valid), .mode(cur_mode)
);

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_ctrl = 1'b0, rd_en = 1'b0, tick = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       out_q, cnt_valid;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tmr_channel dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .tick(tick), .out_q(out_q), .cnt_valid(cnt_valid)
    );

    // vector: mode[44:43] fmt[42:41] count[40:25] ticks[24:17] exp_out[16] exp_cnt[15:0]
    localparam int NV = 12;
    localparam logic [44:0] VECS [NV] = '{
        {2'd0, 2'd3, 16'd5,      8'd3, 1'b0, 16'd3},      // R2
        {2'd0, 2'd3, 16'd5,      8'd6, 1'b1, 16'd0},      // R3
        {2'd0, 2'd3, 16'd2,      8'd5, 1'b1, 16'hFFFE},   // R3 wrap
        {2'd0, 2'd1, 16'h0007,   8'd1, 1'b0, 16'h0007},   // R7 low only
        {2'd0, 2'd2, 16'h0300,   8'd2, 1'b0, 16'h02FF},   // R7 high only
        {2'd1, 2'd3, 16'd4,      8'd3, 1'b1, 16'd2},      // R4
        {2'd1, 2'd3, 16'd4,      8'd4, 1'b0, 16'd1},      // R4 pulse
        {2'd1, 2'd3, 16'd4,      8'd5, 1'b1, 16'd4},      // R4 reload
        {2'd1, 2'd3, 16'd4,      8'd8, 1'b0, 16'd1},      // R4 second period
        {2'd2, 2'd3, 16'd3,      8'd3, 1'b1, 16'd1},      // R5
        {2'd2, 2'd3, 16'd3,      8'd4, 1'b0, 16'd0},      // R5 pulse
        {2'd2, 2'd3, 16'd3,      8'd5, 1'b1, 16'hFFFF}    // R5 no reload
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic ctrl, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ctrl = ctrl; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_ctrl = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic rd(output logic [7:0] b);
        @(negedge clk);
        b = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic load(input logic [1:0] fmt, input logic [15:0] n);
        if (fmt == 2'd1)      wr(1'b0, n[7:0]);
        else if (fmt == 2'd2) wr(1'b0, n[15:8]);
        else begin wr(1'b0, n[7:0]); wr(1'b0, n[15:8]); end
    endtask

    task automatic rd_word(input logic [1:0] fmt, output logic [15:0] w);
        logic [7:0] a, b;
        w = '0;
        if (fmt == 2'd1)      begin rd(a); w[7:0]  = a; end
        else if (fmt == 2'd2) begin rd(a); w[15:8] = a; end
        else begin rd(a); rd(b); w = {b, a}; end
    endtask

    function automatic logic [15:0] fmask(input logic [1:0] fmt);
        return (fmt == 2'd1) ? 16'h00FF : (fmt == 2'd2) ? 16'hFF00 : 16'hFFFF;
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        chk("reset out_q R2", out_q, 0);
        chk("reset cnt_valid R6", cnt_valid, 0);
        chk("reset rd_data R8", rd_data, 0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            logic [1:0]  md, ft;
            logic [15:0] n, ec;
            logic [7:0]  t;
            logic        eo;
            {md, ft, n, t, eo, ec} = VECS[v];
            wr(1'b1, {4'h0, ft, md});
            load(ft, n);
            ticks(int'(t));
            chk($sformatf("vec%0d out_q R2/R3/R4/R5", v), out_q, eo);
            chk($sformatf("vec%0d cnt_valid R6", v), cnt_valid, 1);
            wr(1'b1, 8'h80);
            rd_word(ft, w);
            chk($sformatf("vec%0d count R7", v), w, ec & fmask(ft));
        end

        // R1: control write halts a running rate count
        wr(1'b1, 8'h0D); load(2'd3, 16'd10); ticks(4);
        wr(1'b1, 8'h0D);
        chk("R1 valid cleared", cnt_valid, 0);
        chk("R1 rate idle high R4", out_q, 1);
        ticks(6);
        chk("R1 no output event", out_q, 1);
        wr(1'b1, 8'h80); rd_word(2'd3, w);
        chk("R1 count frozen", w, 16'd7);
        // R6: load waits for a tick
        load(2'd3, 16'd20);
        chk("R6 invalid before tick", cnt_valid, 0);
        ticks(1);
        chk("R6 valid after tick", cnt_valid, 1);
        rd_word(2'd3, w);
        chk("R6 live count", w, 16'd20);

        // R7: first byte freezes, second completes
        wr(1'b1, 8'h0C); load(2'd3, 16'd100); ticks(3);
        wr(1'b0, 8'h10); ticks(5);
        wr(1'b1, 8'h80); rd_word(2'd3, w);
        chk("R7 first byte freezes", w, 16'd98);
        chk("R2 low during reload", out_q, 0);
        wr(1'b0, 8'h00); ticks(1);
        rd_word(2'd3, w);
        chk("R7 second byte arms", w, 16'h0010);

        // R2: count write drops a one-shot output that had gone high
        wr(1'b1, 8'h04); load(2'd1, 16'd2); ticks(3);
        chk("R3 terminal high", out_q, 1);
        wr(1'b0, 8'h05);
        chk("R2 count write drops out", out_q, 0);

        // R8: latch snapshot, second latch ignored
        wr(1'b1, 8'h0C); load(2'd3, 16'h1234); ticks(1);
        wr(1'b1, 8'h80); ticks(4);
        wr(1'b1, 8'h80);
        rd_word(2'd3, w);
        chk("R8 held value", w, 16'h1234);
        rd_word(2'd3, w);
        chk("R8 live after release", w, 16'h1230);

        // R9: control write resets byte order
        wr(1'b1, 8'h0C); load(2'd3, 16'h0A0B); ticks(1);
        rd(b);
        chk("R9 first byte low", b, 8'h0B);
        wr(1'b1, 8'h0C);
        rd(b);
        chk("R9 order reset low", b, 8'h0B);
        rd(b);
        chk("R9 then high", b, 8'h0A);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule